// File: doc/BRIEF.md
# Floating-Point Coded Symbol Rate Generator

This block derives a symbol strobe from the system clock. The wanted rate is written as a small floating-point code: an 8-bit stored mantissa with an implied leading one above it, which makes a 9-bit significand, and a 4-bit binary exponent. On each enabled clock the significand, shifted left by the exponent, is added to a 28-bit phase accumulator. Every carry out of the top bit produces a one-cycle strobe. The average strobe rate is therefore f_clk × (256 + M) × 2^E / 2^28.

The code is read straight from the inputs on every increment. A new mantissa or exponent takes effect on the next enabled edge and keeps the current phase. A synchronous clear input restarts the phase from zero, so several generators can be aligned. The suggested power-up code is exponent 12 with mantissa 0x22. With a 26 MHz clock that code gives about 115.05 kBaud.

Top module: `symrate_gen`

## Requirements
- R1: On each clock edge where `en` is 1 and `clr` and `rst` are 0, `phase` becomes (phase + ((256 + mant) << expo)) mod 2^28, using the `mant` and `expo` present at that edge.
- R2: `tick` is 1 for exactly the cycle after an edge at which the R1 addition carried past 2^28, and is 0 after every other edge.
- R3: On an edge where `en` is 0 and `clr` and `rst` are 0, `phase` keeps its value and `tick` is 0.
- R4: On an edge where `clr` is 1, `phase` becomes 0 and `tick` is 0, whatever `en` is and even where the addition would have carried.
- R5: On an edge where `rst` is 1, `phase` becomes 0 and `tick` is 0, taking priority over `clr` and `en`.
- R6: A change of `mant` or `expo` alters only the step size used from the next enabled edge on. It neither clears nor shifts the accumulated phase.
- R7: Starting from phase 0 and enabled on every clock, the number of ticks seen over W cycles is within ±1 of W × (256 + M) × 2^E / 2^28. The default code (E = 12, M = 0x22) gives 145 ticks in 2^15 cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Advance the accumulator on this edge |
| clr | input | 1 | Synchronous phase clear, tick suppressed |
| mant | input | 8 | Stored mantissa field (implied leading one above it) |
| expo | input | 4 | Exponent field, left shift of the significand |
| tick | output | 1 | One-cycle symbol strobe |
| phase | output | 28 | Current accumulator phase |

## Verification
The bench builds the block with its default widths: an 8-bit mantissa, a 4-bit exponent and a 28-bit accumulator. With these widths the whole code space can be reached, from the smallest step (exponent 0) to the largest step of 0xFF8000 (exponent 15, mantissa 0xFF). The largest step lets a run of 2^15 cycles show thousands of carries. The default code gives an exact count of 145 ticks in that window. A behavioural model using wide integers follows every edge under an irregular enable pattern, periodic clears, code changes in the middle of a run and a reset in the middle of a run.

// File: rtl/symrate_pkg.sv
package symrate_pkg;

    localparam int DEF_MANT_W = 8;
    localparam int DEF_EXP_W  = 4;
    localparam int DEF_ACC_W  = 28;

    localparam logic [DEF_MANT_W-1:0] POWERUP_MANT = 8'h22;
    localparam logic [DEF_EXP_W-1:0]  POWERUP_EXP  = 4'd12;

    // significand width plus largest shift
    function automatic int step_width(input int mant_w, input int exp_w);
        return mant_w + 1 + (2 ** exp_w) - 1;
    endfunction

    typedef enum logic [1:0] {
        ACT_HOLD,
        ACT_STEP,
        ACT_ZERO
    } acc_action_e;

endpackage

// File: rtl/symrate_step.sv
module symrate_step #(
    parameter int MANT_W = symrate_pkg::DEF_MANT_W,
    parameter int EXP_W  = symrate_pkg::DEF_EXP_W,
    parameter int STEP_W = symrate_pkg::step_width(MANT_W, EXP_W)
) (
    input  logic [MANT_W-1:0] mant,
    input  logic [EXP_W-1:0]  expo,
    output logic [STEP_W-1:0] step
);
    localparam int SIG_W = MANT_W + 1;

    logic [STEP_W-1:0] stage [EXP_W+1];

    assign stage[0] = {{(STEP_W-SIG_W){1'b0}}, 1'b1, mant};

    for (genvar k = 0; k < EXP_W; k++) begin : g_shift
        assign stage[k+1] = expo[k] ? (stage[k] << (2 ** k)) : stage[k];
    end

    assign step = stage[EXP_W];

endmodule

// File: rtl/symrate_acc.sv
module symrate_acc #(
    parameter int ACC_W  = symrate_pkg::DEF_ACC_W,
    parameter int STEP_W = 24
) (
    input  logic              clk,
    input  logic              rst,
    input  symrate_pkg::acc_action_e action,
    input  logic [STEP_W-1:0] step,
    output logic [ACC_W-1:0]  phase,
    output logic              tick
);
    import symrate_pkg::*;

    logic [ACC_W:0] sum;

    assign sum = {1'b0, phase} + {{(ACC_W+1-STEP_W){1'b0}}, step};

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= '0;
            tick  <= 1'b0;
        end else begin
            unique case (action)
                ACT_ZERO: begin
                    phase <= '0;
                    tick  <= 1'b0;
                end
                ACT_STEP: begin
                    phase <= sum[ACC_W-1:0];
                    tick  <= sum[ACC_W];
                end
                default: begin
                    tick  <= 1'b0;
                end
            endcase
        end
    end

    // R1
    step_advance_chk: assert property (@(posedge clk) disable iff (rst)
        action == ACT_STEP |=> phase == ACC_W'($past(phase) + ACC_W'($past(step))));

    // R2
    wrap_tick_chk: assert property (@(posedge clk) disable iff (rst)
        action == ACT_STEP |=> tick == (phase < $past(phase)));

    // R3
    hold_when_idle_chk: assert property (@(posedge clk) disable iff (rst)
        action == ACT_HOLD |=> $stable(phase) && !tick);

    // R4
    clear_zero_chk: assert property (@(posedge clk) disable iff (rst)
        action == ACT_ZERO |=> phase == '0 && !tick);

    // R5
    reset_zero_chk: assert property (@(posedge clk)
        rst |=> phase == '0 && !tick);

endmodule

// File: rtl/symrate_gen.sv
module symrate_gen #(
    parameter int MANT_W = symrate_pkg::DEF_MANT_W,
    parameter int EXP_W  = symrate_pkg::DEF_EXP_W,
    parameter int ACC_W  = symrate_pkg::DEF_ACC_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic              clr,
    input  logic [MANT_W-1:0] mant,
    input  logic [EXP_W-1:0]  expo,
    output logic              tick,
    output logic [ACC_W-1:0]  phase
);
    import symrate_pkg::*;

    localparam int STEP_W = step_width(MANT_W, EXP_W);

    logic [STEP_W-1:0] step;
    acc_action_e       action;

    always_comb begin
        if (clr)     action = ACT_ZERO;
        else if (en) action = ACT_STEP;
        else         action = ACT_HOLD;
    end

    symrate_step #(
        .MANT_W (MANT_W),
        .EXP_W  (EXP_W),
        .STEP_W (STEP_W)
    ) step_i (
        .mant (mant),
        .expo (expo),
        .step (step)
    );

    symrate_acc #(
        .ACC_W  (ACC_W),
        .STEP_W (STEP_W)
    ) acc_i (
        .clk    (clk),
        .rst    (rst),
        .action (action),
        .step   (step),
        .phase  (phase),
        .tick   (tick)
    );

    // R2
    tick_isolated_chk: assert property (@(posedge clk) disable iff (rst)
        tick |=> !tick);

    // R4
    clear_beats_enable_chk: assert property (@(posedge clk) disable iff (rst)
        clr && en |=> !tick);

endmodule

// File: tb/symrate_gen_tb_top.sv
module symrate_gen_tb_top;

    localparam longint MOD = 64'd1 << 28;
    localparam int     WIN = 32768;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        en  = 1'b0;
    logic        clr = 1'b0;
    logic [7:0]  mant = 8'h22;
    logic [3:0]  expo = 4'd12;
    logic        tick;
    logic [27:0] phase;

    int     errors = 0;
    int     checks = 0;
    bit     done   = 0;
    longint ref_phase = 0;
    bit     ref_tick  = 0;
    bit     counting  = 0;
    int     tick_cnt  = 0;

    always #2.5 clk = ~clk;

    symrate_gen dut_i (
        .clk   (clk),
        .rst   (rst),
        .en    (en),
        .clr   (clr),
        .mant  (mant),
        .expo  (expo),
        .tick  (tick),
        .phase (phase)
    );

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // called at a negedge: drive inputs, predict the next edge, then compare
    task automatic step(input bit r, input bit e, input bit c, input logic [7:0] m, input logic [3:0] x);
        longint nxt;
        rst = r; en = e; clr = c; mant = m; expo = x;
        if (r || c) begin
            ref_phase = 0;
            ref_tick  = 0;
        end else if (e) begin
            nxt = ref_phase + ((256 + longint'(m)) * (longint'(1) << x));
            ref_tick  = (nxt >= MOD);
            ref_phase = nxt % MOD;
        end else begin
            ref_tick = 0;
        end
        @(negedge clk);
        check(longint'(phase) == ref_phase, "R1 R3 R4 R5 R6 phase", longint'(phase), ref_phase);
        check(tick == ref_tick, "R2 R3 R4 R5 tick", longint'(tick), longint'(ref_tick));
        if (counting && tick) tick_cnt++;
    endtask

    task automatic rate_window(input logic [7:0] m, input logic [3:0] x);
        longint expct;
        step(0, 1, 1, m, x);
        counting = 1;
        tick_cnt = 0;
        for (int i = 0; i < WIN; i++) step(0, 1, 0, m, x);
        counting = 0;
        expct = ((256 + longint'(m)) * (longint'(1) << x) * WIN) >> 28;
        check(longint'(tick_cnt) >= expct - 1 && longint'(tick_cnt) <= expct + 1,
              "R7 tick count", longint'(tick_cnt), expct);
    endtask

    initial begin
        logic [15:0] lfsr;
        @(negedge clk);
        step(1, 1, 0, 8'h22, 4'd12);
        step(1, 1, 1, 8'h22, 4'd12);
        // R5 reset state
        check(phase == 28'd0 && tick == 1'b0, "R5 reset state", longint'(phase), 0);

        // R1 first increment with default code: 290 << 12
        step(0, 1, 0, 8'h22, 4'd12);
        check(longint'(phase) == 64'd1187840, "R1 first step", longint'(phase), 1187840);

        // R7 rate windows
        rate_window(8'h22, 4'd12);
        rate_window(8'hFF, 4'd15);
        rate_window(8'h80, 4'd8);

        // R3 irregular enable
        lfsr = 16'hACE1;
        for (int i = 0; i < 3000; i++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            step(0, lfsr[0] & lfsr[3], 0, 8'hFF, 4'd15);
        end

        // R4 clear lands on wrap cycles too: 0xFF8000 step, clear every 37 cycles
        for (int i = 0; i < 2000; i++) step(0, 1, (i % 37) == 36, 8'hFF, 4'd15);
        // R4 clear with a wrap pending: phase near the top, then clear
        for (int i = 0; i < 16; i++) step(0, 1, 0, 8'hFF, 4'd15);
        step(0, 1, 1, 8'hFF, 4'd15);
        check(tick == 1'b0 && phase == 28'd0, "R4 clear suppresses", longint'(tick), 0);

        // R6 code changes mid-run keep phase
        for (int i = 0; i < 2000; i++)
            step(0, 1, 0, 8'(i * 7), 4'((i / 50) % 16));

        // R5 reset mid-run beats clr and en
        step(1, 1, 1, 8'h10, 4'd14);
        check(phase == 28'd0 && tick == 1'b0, "R5 mid-run reset", longint'(phase), 0);
        for (int i = 0; i < 500; i++) step(0, 1, 0, 8'h10, 4'd14);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule